// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from the peripheral clock. A 12-bit divider sets the base period. A mode input chooses standard timing (equal low and high phases) or fast timing. In fast timing a duty input chooses a 2:1 or a 16:9 low-to-high split. The block pulls SCL low through an open-drain enable. When it lets the line go, it watches the line itself, so a slave that holds SCL low stretches the period.

A programmable rise window sets the earliest cycle after release at which high-phase counting may begin. This allows for the slow pull-up edge. The block also checks the peripheral-clock frequency code: if that code is outside its legal range, the block will not start a new period. The bit engine uses a one-cycle strobe at the start of each low phase to shift data, and a one-cycle strobe at the start of each high phase to sample. An activity flag tells it when the clock has stopped.

Divider, mode and duty are read whenever a phase counter is loaded. A change made during a phase therefore takes effect at the next phase.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is asserted and just after it, `scl_pull_low`, `clk_active`, `fall_stb` and `rise_stb` are all 0.
- R2: In standard mode (`fast_mode`=0) the low phase and the high phase each last D cycles, where D is the effective divider.
- R3: In fast mode with `duty_16_9`=0, the low phase lasts 2×D cycles and the high phase D cycles.
- R4: In fast mode with `duty_16_9`=1, the low phase lasts 16×D cycles and the high phase 9×D cycles.
- R5: The effective divider D is `div_val` clamped from below: to 4 in standard mode and to 1 in fast mode.
- R6: After SCL is released, high-phase counting begins no earlier than `rise_ticks`+1 cycles later. With the line already high, `rise_stb` appears exactly `rise_ticks`+1 cycles after `scl_pull_low` falls.
- R7: While `scl_in` is held low after release, no high phase starts. Once `scl_in` is seen high and the rise window has expired, `rise_stb` follows one cycle later, and the high phase that follows has its full length.
- R8: A new period (from idle, or after a high phase) starts only if `freq_mhz` lies in the range 2 to 42 inclusive. Otherwise the block stays idle with SCL released.
- R9: From idle, a period starts on the cycle after `enable` is seen high. If `enable` drops, the current period runs to the end of its high phase, and then `clk_active` falls with SCL released.
- R10: `fall_stb` is high for exactly the first cycle of each low phase, and `rise_stb` for exactly the first cycle of each high phase.
- R11: Divider, mode and duty are read when a phase is loaded. A change during a phase does not alter that phase's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request from the bit engine |
| div_val | input | 12 | Base divider |
| fast_mode | input | 1 | 1 selects fast timing |
| duty_16_9 | input | 1 | In fast timing: 1 gives 16:9 low:high, 0 gives 2:1 |
| freq_mhz | input | 6 | Peripheral clock frequency in MHz; legal values are 2 to 42 |
| rise_ticks | input | 6 | Rise window length after release, in cycles |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull_low | output | 1 | Open-drain enable: 1 drives SCL low |
| clk_active | output | 1 | A clock period is in progress |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a high phase |

## Verification
The bench measures low, release-gap and high lengths in each mode. Divider values below the minimum show whether the clamp is applied per mode; a design that ignores it would produce a one- or two-cycle standard-mode clock. A slave stretch longer than the rise window catches a generator that starts counting the high phase on a timer instead of on the line level; such a design would shorten the high phase or put the sample strobe too early. Frequency codes 1, 2, 42 and 43 probe the off-by-one edges of the legal range. A divider change in the middle of a phase reveals a design that reads its configuration continuously and so truncates the running phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_RISE = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

endpackage

// File: rtl/scl_cfg_check.sv
module scl_cfg_check #(
    parameter int FREQ_W   = 6,
    parameter int FREQ_MIN = 2,
    parameter int FREQ_MAX = 42
) (
    input  logic [FREQ_W-1:0] freq_mhz,
    output logic              cfg_ok
);
    localparam logic [FREQ_W-1:0] LO_V = FREQ_W'(FREQ_MIN);
    localparam logic [FREQ_W-1:0] HI_V = FREQ_W'(FREQ_MAX);

    always_comb begin
        cfg_ok = (freq_mhz >= LO_V) && (freq_mhz <= HI_V);
    end
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc #(
    parameter int DIV_W    = 12,
    parameter int CNT_W    = 16,
    parameter int MIN_STD  = 4,
    parameter int MIN_FAST = 1
) (
    input  logic [DIV_W-1:0] div_val,
    input  logic             fast_mode,
    input  logic             duty_16_9,
    output logic [CNT_W-1:0] low_ticks,
    output logic [CNT_W-1:0] high_ticks
);
    localparam logic [DIV_W-1:0] STD_FLOOR  = DIV_W'(MIN_STD);
    localparam logic [DIV_W-1:0] FAST_FLOOR = DIV_W'(MIN_FAST);

    logic [DIV_W-1:0] eff_div;
    logic [CNT_W-1:0] eff_ext;

    always_comb begin
        if (fast_mode) begin
            eff_div = (div_val < FAST_FLOOR) ? FAST_FLOOR : div_val;
        end else begin
            eff_div = (div_val < STD_FLOOR) ? STD_FLOOR : div_val;
        end
        eff_ext = CNT_W'(eff_div);

        if (!fast_mode) begin
            low_ticks  = eff_ext;
            high_ticks = eff_ext;
        end else if (duty_16_9) begin
            low_ticks  = eff_ext << 4;
            high_ticks = (eff_ext << 3) + eff_ext;
        end else begin
            low_ticks  = eff_ext << 1;
            high_ticks = eff_ext;
        end
    end
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
    parameter int DIV_W    = 12,
    parameter int FREQ_W   = 6,
    parameter int RISE_W   = 6,
    parameter int FREQ_MIN = 2,
    parameter int FREQ_MAX = 42,
    parameter int MIN_STD  = 4,
    parameter int MIN_FAST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              fast_mode,
    input  logic              duty_16_9,
    input  logic [FREQ_W-1:0] freq_mhz,
    input  logic [RISE_W-1:0] rise_ticks,
    input  logic              scl_in,
    output logic              scl_pull_low,
    output logic              clk_active,
    output logic              fall_stb,
    output logic              rise_stb
);
    import scl_gen_pkg::*;

    // 16x multiplier of the low phase needs four extra counter bits
    localparam int CNT_W = DIV_W + 4;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        scl_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             fall_stb;
        logic             rise_stb;
    } gen_state_t;

    gen_state_t       st_d, st_q;
    logic             cfg_ok;
    logic [CNT_W-1:0] low_ticks, high_ticks;

    scl_cfg_check #(
        .FREQ_W  (FREQ_W),
        .FREQ_MIN(FREQ_MIN),
        .FREQ_MAX(FREQ_MAX)
    ) i_cfg (
        .freq_mhz(freq_mhz),
        .cfg_ok  (cfg_ok)
    );

    scl_phase_calc #(
        .DIV_W   (DIV_W),
        .CNT_W   (CNT_W),
        .MIN_STD (MIN_STD),
        .MIN_FAST(MIN_FAST)
    ) i_calc (
        .div_val   (div_val),
        .fast_mode (fast_mode),
        .duty_16_9 (duty_16_9),
        .low_ticks (low_ticks),
        .high_ticks(high_ticks)
    );

    always_comb begin
        st_d          = st_q;
        st_d.fall_stb = 1'b0;
        st_d.rise_stb = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (enable && cfg_ok) begin
                    st_d.phase    = PH_LOW;
                    st_d.cnt      = low_ticks - ONE;
                    st_d.fall_stb = 1'b1;
                end
            end
            PH_LOW: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_RISE;
                    st_d.cnt   = CNT_W'(rise_ticks);
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_RISE: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE;
                end else if (scl_in) begin
                    st_d.phase    = PH_HIGH;
                    st_d.cnt      = high_ticks - ONE;
                    st_d.rise_stb = 1'b1;
                end
            end
            PH_HIGH: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE;
                end else if (enable && cfg_ok) begin
                    st_d.phase    = PH_LOW;
                    st_d.cnt      = low_ticks - ONE;
                    st_d.fall_stb = 1'b1;
                end else begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, fall_stb: 1'b0, rise_stb: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_pull_low = (st_q.phase == PH_LOW);
    assign clk_active   = (st_q.phase != PH_IDLE);
    assign fall_stb     = st_q.fall_stb;
    assign rise_stb     = st_q.rise_stb;

    // R10: strobes last a single cycle
    a_r10_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);
    a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);
    // R10: fall strobe coincides with SCL being driven low
    a_r10_fall_with_pull: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> scl_pull_low);
    // R7: a high phase starts only after the line was seen high
    a_r7_rise_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rise_stb) |-> $past(scl_in));
    // R6: no high phase while the rise window is still open
    a_r6_window_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RISE && st_q.cnt != '0) |=> !rise_stb);
    // R8: SCL is only pulled low for a new period with a legal frequency code
    a_r8_start_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> $past(cfg_ok && enable));
    // R9: the clock stops with SCL released
    a_r9_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_active) |-> (!scl_pull_low && !$past(scl_pull_low)));
endmodule

// File: tb/test_scl_clock_gen.sv
module test_scl_clock_gen;
    localparam time HALF = 2.5ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [11:0] div_val = 12'd10;
    logic        fast_mode = 1'b0;
    logic        duty_16_9 = 1'b0;
    logic [5:0]  freq_mhz = 6'd16;
    logic [5:0]  rise_ticks = 6'd0;
    logic        stretch_hold = 1'b0;
    logic        scl_in;
    logic        scl_pull_low, clk_active, fall_stb, rise_stb;

    int errors = 0;
    int checks = 0;

    always #HALF clk = ~clk;

    // open-drain bus model: pulled low by the master or by a stretching slave
    assign scl_in = ~scl_pull_low & ~stretch_hold;

    scl_clock_gen i_scl_clock_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .div_val     (div_val),
        .fast_mode   (fast_mode),
        .duty_16_9   (duty_16_9),
        .freq_mhz    (freq_mhz),
        .rise_ticks  (rise_ticks),
        .scl_in      (scl_in),
        .scl_pull_low(scl_pull_low),
        .clk_active  (clk_active),
        .fall_stb    (fall_stb),
        .rise_stb    (rise_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fall(input string req);
        int n = 0;
        while (!fall_stb && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " fall strobe seen"}, int'(fall_stb), 1);
    endtask

    task automatic count_low(output int lo);
        lo = 0;
        while (scl_pull_low && lo < 70000) begin
            lo++;
            @(negedge clk);
        end
    endtask

    task automatic count_gap(output int gap);
        gap = 0;
        while (!rise_stb && gap < 5000) begin
            gap++;
            @(negedge clk);
        end
    endtask

    task automatic count_high(output int hi);
        hi = 0;
        while (!scl_pull_low && clk_active && hi < 70000) begin
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input string req, output int lo, output int gap, output int hi);
        wait_fall(req);
        count_low(lo);
        count_gap(gap);
        count_high(hi);
    endtask

    task automatic stop_gen();
        int n = 0;
        enable = 1'b0;
        while (clk_active && n < 70000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 pull in reset", int'(scl_pull_low), 0);
        chk("R1 active in reset", int'(clk_active), 0);
        chk("R1 strobes in reset", int'(fall_stb | rise_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pull after reset", int'(scl_pull_low), 0);
        chk("R1 active after reset", int'(clk_active), 0);
    endtask

    task automatic t_start_latency();
        fast_mode = 0; div_val = 12'd6; rise_ticks = 6'd0; freq_mhz = 6'd16;
        enable = 1'b1;
        @(negedge clk);
        chk("R9 start one cycle after enable", int'(fall_stb), 1);
        @(negedge clk);
        chk("R10 fall strobe single cycle", int'(fall_stb), 0);
        stop_gen();
    endtask

    task automatic t_standard();
        int lo, gap, hi;
        fast_mode = 0; duty_16_9 = 0; div_val = 12'd10; rise_ticks = 6'd0;
        enable = 1'b1;
        measure("R2", lo, gap, hi);
        measure("R2", lo, gap, hi);
        chk("R2 standard low", lo, 10);
        chk("R2 standard high", hi, 10);
        chk("R6 gap with zero window", gap, 1);
        stop_gen();
    endtask

    task automatic t_fast_duty0();
        int lo, gap, hi;
        fast_mode = 1; duty_16_9 = 0; div_val = 12'd5; rise_ticks = 6'd0;
        enable = 1'b1;
        measure("R3", lo, gap, hi);
        measure("R3", lo, gap, hi);
        chk("R3 fast 2:1 low", lo, 10);
        chk("R3 fast 2:1 high", hi, 5);
        stop_gen();
    endtask

    task automatic t_fast_duty1();
        int lo, gap, hi;
        fast_mode = 1; duty_16_9 = 1; div_val = 12'd3; rise_ticks = 6'd0;
        enable = 1'b1;
        measure("R4", lo, gap, hi);
        chk("R4 fast 16:9 low", lo, 48);
        chk("R4 fast 16:9 high", hi, 27);
        stop_gen();
    endtask

    task automatic t_clamp();
        int lo, gap, hi;
        fast_mode = 0; duty_16_9 = 0; div_val = 12'd2; rise_ticks = 6'd0;
        enable = 1'b1;
        measure("R5", lo, gap, hi);
        chk("R5 standard floor low", lo, 4);
        chk("R5 standard floor high", hi, 4);
        stop_gen();
        fast_mode = 1; duty_16_9 = 0; div_val = 12'd0;
        enable = 1'b1;
        measure("R5", lo, gap, hi);
        chk("R5 fast floor low", lo, 2);
        chk("R5 fast floor high", hi, 1);
        stop_gen();
    endtask

    task automatic t_rise();
        int lo, gap, hi;
        fast_mode = 0; duty_16_9 = 0; div_val = 12'd8; rise_ticks = 6'd5;
        enable = 1'b1;
        measure("R6", lo, gap, hi);
        chk("R6 rise window gap", gap, 6);
        chk("R6 high after window", hi, 8);
        stop_gen();
        rise_ticks = 6'd0;
    endtask

    task automatic t_stretch();
        int lo, gap, hi, seen;
        fast_mode = 0; duty_16_9 = 0; div_val = 12'd7; rise_ticks = 6'd2;
        stretch_hold = 1'b1;
        enable = 1'b1;
        wait_fall("R7");
        count_low(lo);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (rise_stb) seen = 1;
            @(negedge clk);
        end
        chk("R7 no high phase while stretched", seen, 0);
        stretch_hold = 1'b0;
        count_gap(gap);
        count_high(hi);
        chk("R7 rise one cycle after line high", gap, 1);
        chk("R7 full high after stretch", hi, 7);
        stop_gen();
        rise_ticks = 6'd0;
    endtask

    task automatic t_freq_range();
        int seen;
        fast_mode = 0; div_val = 12'd4;
        freq_mhz = 6'd1;
        enable = 1'b1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (fall_stb || clk_active || scl_pull_low) seen = 1;
        end
        chk("R8 code 1 keeps idle", seen, 0);
        enable = 1'b0;
        freq_mhz = 6'd43;
        enable = 1'b1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (fall_stb || clk_active || scl_pull_low) seen = 1;
        end
        chk("R8 code 43 keeps idle", seen, 0);
        enable = 1'b0;
        @(negedge clk);
        freq_mhz = 6'd42;
        enable = 1'b1;
        @(negedge clk);
        chk("R8 code 42 starts", int'(fall_stb), 1);
        stop_gen();
        freq_mhz = 6'd2;
        enable = 1'b1;
        @(negedge clk);
        chk("R8 code 2 starts", int'(fall_stb), 1);
        stop_gen();
        freq_mhz = 6'd16;
    endtask

    task automatic t_disable();
        int lo, gap, hi, bad;
        fast_mode = 0; duty_16_9 = 0; div_val = 12'd9; rise_ticks = 6'd0;
        enable = 1'b1;
        wait_fall("R9");
        enable = 1'b0;
        count_low(lo);
        count_gap(gap);
        count_high(hi);
        chk("R9 low completes after disable", lo, 9);
        chk("R9 high completes after disable", hi, 9);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (clk_active || scl_pull_low || fall_stb) bad = 1;
            @(negedge clk);
        end
        chk("R9 stays idle and released", bad, 0);
    endtask

    task automatic t_cfg_latch();
        int lo, gap, hi;
        fast_mode = 0; duty_16_9 = 0; div_val = 12'd10; rise_ticks = 6'd0;
        enable = 1'b1;
        wait_fall("R11");
        div_val = 12'd20;
        count_low(lo);
        count_gap(gap);
        count_high(hi);
        chk("R11 running low keeps old divider", lo, 10);
        chk("R11 next phase uses new divider", hi, 20);
        stop_gen();
    endtask

    initial begin
        #(HALF * 2 * 150000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_start_latency();
        t_standard();
        t_fast_duty0();
        t_fast_duty1();
        t_clamp();
        t_rise();
        t_stretch();
        t_freq_range();
        t_disable();
        t_cfg_latch();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule